// File: doc/BRIEF.md
# Flash Command Access Gate

This block stands between the serial command decoder of an in-system flash programming port and the flash controller. Every command the decoder presents (read, program, block erase, status read) is given a single-cycle verdict: granted and passed on, or refused. A non-blank flash is locked after reset. It opens only when the host sends a seven-byte identification sequence that matches the stored ID byte for byte. A blank flash opens without any identification.

Once the gate is open, a second rule still applies. Program and erase requests aimed at the boot area are always refused. Addresses outside the selected area are refused as well. For each granted user-area command the gate reports which erase block the address falls in, so the erase sequencer can target it. Refusals also set a sticky error flag that a later status read can return.

Top module: `flash_cmd_gate`

## Requirements
- R1: After a synchronous reset, `cmd_grant`, `cmd_reject`, `unlocked` and `err_sticky` are 0 and `blk_idx` is 3.
- R2: If `flash_blank` is 1 at a clock edge, `unlocked` is 1 after that edge. A command sampled at that same edge is not refused for lock reasons.
- R3: While `unlocked` and `flash_blank` are both 0, every command is refused.
- R4: An ID sequence unlocks the gate at the edge that samples its seventh byte when all of the following hold:
  - the first byte is sampled with `id_start`=1;
  - seven bytes are sampled with `id_valid`=1;
  - byte i equals `stored_id[8*i+7:8*i]`.
- R5: A single mismatching byte leaves the gate locked. Later bytes without `id_start` cannot repair the sequence; a new sequence beginning with `id_start` is needed.
- R6: Once `unlocked` is 1, it stays 1 until reset, even after `flash_blank` falls.
- R7: With `area_sel`=1 (boot area), program (`cmd_op`=1) and erase (`cmd_op`=2) are always refused.
- R8: A command is refused when its address is outside the selected area. The user area (`area_sel`=0) is 8000h–FFFFh and the boot area is F000h–FFFFh. Reads (`cmd_op`=0) and status reads (`cmd_op`=3) in range of an open gate are granted.
- R9: On a granted user-area command, `blk_idx` is 0 for E000h–FFFFh, 1 for C000h–DFFFh and 2 for 8000h–BFFFh. On a granted boot command, on a refusal and when idle, `blk_idx` is 3.
- R10: A command sampled at an edge with `cmd_valid`=1 yields exactly one of `cmd_grant`/`cmd_reject`, high for exactly the following cycle. No edge without `cmd_valid` yields either.
- R11: `err_sticky` rises together with the first `cmd_reject` pulse and holds until reset.
- R12: ID bytes are ignored when no sequence is open, that is, before any `id_start` and after the seventh byte of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | ID byte strobe |
| id_start | input | 1 | Marks the first byte of an ID sequence |
| id_byte | input | 8 | ID byte from the host |
| stored_id | input | 56 | Stored ID, byte i at bits 8i+7:8i |
| flash_blank | input | 1 | Flash contains no data |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | 0 read, 1 program, 2 erase, 3 status read |
| cmd_addr | input | 16 | Target address |
| area_sel | input | 1 | 0 user area, 1 boot area |
| cmd_grant | output | 1 | One-cycle grant pulse |
| cmd_reject | output | 1 | One-cycle refusal pulse |
| blk_idx | output | 2 | User erase block of the granted address, 3 when none |
| unlocked | output | 1 | Gate open |
| err_sticky | output | 1 | A command has been refused since reset |

## Verification
On every cycle, the assertions check the following:
- a locked gate and boot-area writes always draw a refusal;
- verdicts are single, exclusive and come only one cycle after a request;
- the open state and the error flag never fall;
- a refusal never carries a block index.

Only the bench scenarios can show the rest:
- that the right seven bytes actually open the gate and that a corrupted or unstarted sequence does not;
- that stray bytes are ignored;
- that the block boundaries land on the right addresses.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

    localparam int ID_LEN = 7;
    localparam int ADDR_W = 16;

    localparam logic [15:0] USER_LO = 16'h8000;
    localparam logic [15:0] BLK1_LO = 16'hC000;
    localparam logic [15:0] BLK0_LO = 16'hE000;
    localparam logic [15:0] BOOT_LO = 16'hF000;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_STAT  = 2'd3
    } op_e;

    localparam logic [1:0] BLK_NONE = 2'd3;

    typedef struct packed {
        logic       grant;
        logic       reject;
        logic [1:0] blk;
    } verdict_t;

    function automatic logic op_modifies(op_e op);
        return (op == OP_PROG) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/fgate_id_match.sv
module fgate_id_match #(
    parameter int ID_LEN = fgate_pkg::ID_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                id_valid,
    input  logic                id_start,
    input  logic [7:0]          id_byte,
    input  logic [8*ID_LEN-1:0] stored_id,
    output logic                match
);
    localparam int IDX_W = $clog2(ID_LEN + 1);

    logic [7:0]       ref_b [ID_LEN];
    logic [IDX_W-1:0] cnt_q;
    logic             ok_q;
    logic [IDX_W-1:0] pos;
    logic             accept;
    logic             hit;
    logic             ok_n;

    for (genvar g = 0; g < ID_LEN; g++) begin : g_ref
        assign ref_b[g] = stored_id[8*g +: 8];
    end

    always_comb begin
        pos    = id_start ? '0 : cnt_q;
        accept = id_valid && (id_start ||
                 (cnt_q != '0 && cnt_q < IDX_W'(ID_LEN)));
        hit    = (pos < IDX_W'(ID_LEN)) && (id_byte == ref_b[pos]);
        ok_n   = (id_start ? 1'b1 : ok_q) && hit;
        match  = accept && ok_n && (pos == IDX_W'(ID_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else if (accept) begin
            cnt_q <= pos + IDX_W'(1);
            ok_q  <= ok_n;
        end
    end
endmodule

// File: rtl/fgate_region.sv
module fgate_region #(
    parameter int                ADDR_W  = fgate_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] USER_LO = ADDR_W'(fgate_pkg::USER_LO),
    parameter logic [ADDR_W-1:0] BLK1_LO = ADDR_W'(fgate_pkg::BLK1_LO),
    parameter logic [ADDR_W-1:0] BLK0_LO = ADDR_W'(fgate_pkg::BLK0_LO),
    parameter logic [ADDR_W-1:0] BOOT_LO = ADDR_W'(fgate_pkg::BOOT_LO)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              area_sel,
    output logic              in_range,
    output logic [1:0]        blk
);
    import fgate_pkg::*;

    always_comb begin
        in_range = area_sel ? (addr >= BOOT_LO) : (addr >= USER_LO);
        if (area_sel)             blk = BLK_NONE;
        else if (addr >= BLK0_LO) blk = 2'd0;
        else if (addr >= BLK1_LO) blk = 2'd1;
        else if (addr >= USER_LO) blk = 2'd2;
        else                      blk = BLK_NONE;
    end
endmodule

// File: rtl/fgate_core.sv
module fgate_core (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  fgate_pkg::op_e      op,
    input  logic                area_sel,
    input  logic                in_range,
    input  logic [1:0]          blk,
    input  logic                flash_blank,
    input  logic                id_match,
    output fgate_pkg::verdict_t verdict,
    output logic                unlocked,
    output logic                err_sticky
);
    import fgate_pkg::*;

    verdict_t vd_n;
    logic     open_now;
    logic     deny;

    always_comb begin
        open_now    = unlocked || flash_blank;
        deny        = !open_now || !in_range || (area_sel && op_modifies(op));
        vd_n.grant  = cmd_valid && !deny;
        vd_n.reject = cmd_valid && deny;
        vd_n.blk    = vd_n.grant ? blk : BLK_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict    <= '{grant: 1'b0, reject: 1'b0, blk: BLK_NONE};
            unlocked   <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            verdict    <= vd_n;
            unlocked   <= unlocked || flash_blank || id_match;
            err_sticky <= err_sticky || vd_n.reject;
        end
    end
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate #(
    parameter int ID_LEN = fgate_pkg::ID_LEN,
    parameter int ADDR_W = fgate_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                id_valid,
    input  logic                id_start,
    input  logic [7:0]          id_byte,
    input  logic [8*ID_LEN-1:0] stored_id,
    input  logic                flash_blank,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                area_sel,
    output logic                cmd_grant,
    output logic                cmd_reject,
    output logic [1:0]          blk_idx,
    output logic                unlocked,
    output logic                err_sticky
);
    import fgate_pkg::*;

    logic     id_hit;
    logic     in_range;
    logic [1:0] blk;
    verdict_t verdict;

    fgate_id_match #(.ID_LEN(ID_LEN)) u_id (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_start(id_start),
        .id_byte(id_byte), .stored_id(stored_id), .match(id_hit)
    );

    fgate_region #(.ADDR_W(ADDR_W)) u_region (
        .addr(cmd_addr), .area_sel(area_sel), .in_range(in_range), .blk(blk)
    );

    fgate_core u_core (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .op(op_e'(cmd_op)),
        .area_sel(area_sel), .in_range(in_range), .blk(blk),
        .flash_blank(flash_blank), .id_match(id_hit), .verdict(verdict),
        .unlocked(unlocked), .err_sticky(err_sticky)
    );

    assign cmd_grant  = verdict.grant;
    assign cmd_reject = verdict.reject;
    assign blk_idx    = verdict.blk;
endmodule

// File: rtl/fgate_chk.sv
module fgate_chk (
    input logic       clk,
    input logic       rst,
    input logic       flash_blank,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       area_sel,
    input logic       cmd_grant,
    input logic       cmd_reject,
    input logic [1:0] blk_idx,
    input logic       unlocked,
    input logic       err_sticky
);
    a_r3_locked_refused: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !unlocked && !flash_blank |=> cmd_reject && !cmd_grant);

    a_r7_boot_write_refused: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && area_sel && (cmd_op == 2'd1 || cmd_op == 2'd2) |=> cmd_reject);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_grant, cmd_reject}));

    a_r10_verdict_follows: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (cmd_grant || cmd_reject));

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !cmd_grant && !cmd_reject);

    a_r2_blank_opens: assert property (@(posedge clk) disable iff (rst)
        flash_blank |=> unlocked);

    a_r6_unlock_holds: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);

    a_r11_err_with_reject: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> err_sticky);

    a_r11_err_holds: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    a_r9_no_blk_on_reject: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> blk_idx == 2'd3);
endmodule

bind flash_cmd_gate fgate_chk u_chk (
    .clk(clk), .rst(rst), .flash_blank(flash_blank), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .area_sel(area_sel), .cmd_grant(cmd_grant),
    .cmd_reject(cmd_reject), .blk_idx(blk_idx), .unlocked(unlocked),
    .err_sticky(err_sticky)
);

// File: tb/flash_cmd_gate_bench.sv
module flash_cmd_gate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        id_valid = 1'b0, id_start = 1'b0;
    logic [7:0]  id_byte = 8'h00;
    logic [55:0] stored_id = 56'h0D1C2B3A495867;
    logic        flash_blank = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_addr = 16'h0000;
    logic        area_sel = 1'b0;
    logic        cmd_grant, cmd_reject, unlocked, err_sticky;
    logic [1:0]  blk_idx;

    always #10 clk = ~clk;

    flash_cmd_gate u_flash_cmd_gate (
        .clk(clk), .rst(rst), .id_valid(id_valid), .id_start(id_start),
        .id_byte(id_byte), .stored_id(stored_id), .flash_blank(flash_blank),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .area_sel(area_sel), .cmd_grant(cmd_grant), .cmd_reject(cmd_reject),
        .blk_idx(blk_idx), .unlocked(unlocked), .err_sticky(err_sticky)
    );

    typedef struct {
        int         due;
        logic       g;
        logic [1:0] b;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic m_unl = 1'b0;
    logic done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each verdict in the cycle it is due.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " grant"},  int'(cmd_grant),  int'(e.g));
                check({e.tag, " reject"}, int'(cmd_reject), int'(!e.g));
                check({e.tag, " blk_idx R9"}, int'(blk_idx), int'(e.b));
            end else if (cmd_grant || cmd_reject) begin
                check("R10 unexpected verdict", 1, 0);
            end
        end
    end

    function automatic void model(input logic [1:0] op, input logic [15:0] a,
                                  input logic area, input logic open,
                                  output logic g, output logic [1:0] b);
        g = 1'b0;
        b = 2'd3;
        if (!open) return;
        if (area) begin
            if (op == 2'd1 || op == 2'd2) return;
            g = (a >= 16'hF000);
            return;
        end
        if (a < 16'h8000) return;
        g = 1'b1;
        b = (a >= 16'hE000) ? 2'd0 : (a >= 16'hC000) ? 2'd1 : 2'd2;
    endfunction

    task automatic issue(input string tag, input logic [1:0] op,
                         input logic [15:0] a, input logic area);
        exp_t e;
        logic g;
        logic [1:0] b;
        model(op, a, area, m_unl || flash_blank, g, b);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; area_sel = area;
        e.due = cyc + 1; e.g = g; e.b = b; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_id(input int bad_pos, input logic with_start, input int n);
        for (int i = 0; i < n; i++) begin
            id_valid = 1'b1;
            id_start = with_start && (i == 0);
            id_byte  = stored_id[8*i +: 8] ^ ((i == bad_pos) ? 8'h5A : 8'h00);
            @(negedge clk);
        end
        id_valid = 1'b0;
        id_start = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        sb.delete();
        m_unl = 1'b0;
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        #2;
        // R1 reset state
        check("R1 grant", int'(cmd_grant), 0);
        check("R1 reject", int'(cmd_reject), 0);
        check("R1 unlocked", int'(unlocked), 0);
        check("R1 err_sticky", int'(err_sticky), 0);
        check("R1 blk_idx", int'(blk_idx), 3);
        @(negedge clk);

        // R3 locked gate refuses; R11 sticky error
        issue("R3 read locked", 2'd0, 16'h9000, 1'b0);
        issue("R3 status locked", 2'd3, 16'hF000, 1'b0);
        idle(1);
        check("R11 err set", int'(err_sticky), 1);
        idle(3);
        check("R11 err held", int'(err_sticky), 1);
        @(negedge clk);

        // R12 correct bytes with no start are ignored
        send_id(-1, 1'b0, 7);
        idle(1);
        check("R12 no start stays locked", int'(unlocked), 0);
        @(negedge clk);

        // R5 one bad byte, then repair attempt without start
        send_id(3, 1'b1, 7);
        idle(1);
        check("R5 mismatch locked", int'(unlocked), 0);
        @(negedge clk);
        send_id(-1, 1'b0, 7);
        idle(1);
        check("R5 no repair without start", int'(unlocked), 0);
        @(negedge clk);
        issue("R5 still refused", 2'd0, 16'hE000, 1'b0);

        // R4 correct sequence opens the gate at the seventh byte
        send_id(-1, 1'b1, 6);
        idle(1);
        check("R4 six bytes not enough", int'(unlocked), 0);
        @(negedge clk);
        send_id(-1, 1'b1, 7);
        #2;
        check("R4 unlocked", int'(unlocked), 1);
        m_unl = 1'b1;
        @(negedge clk);
        // R12 extra bytes after sequence ignored
        send_id(1, 1'b0, 3);
        idle(1);
        check("R12 extra bytes harmless", int'(unlocked), 1);
        @(negedge clk);

        // R8 / R9 / R7 / R10 back-to-back commands
        issue("R9 blk0 read", 2'd0, 16'hE100, 1'b0);
        issue("R9 blk0 top", 2'd1, 16'hFFFF, 1'b0);
        issue("R9 blk1 program", 2'd1, 16'hC000, 1'b0);
        issue("R9 blk1 edge", 2'd2, 16'hDFFF, 1'b0);
        issue("R9 blk2 erase", 2'd2, 16'h8000, 1'b0);
        issue("R9 blk2 edge", 2'd0, 16'hBFFF, 1'b0);
        issue("R8 below user", 2'd0, 16'h7FFF, 1'b0);
        issue("R7 boot program", 2'd1, 16'hF000, 1'b1);
        issue("R7 boot erase", 2'd2, 16'hFFFF, 1'b1);
        issue("R8 boot read", 2'd0, 16'hF800, 1'b1);
        issue("R8 boot status", 2'd3, 16'hF000, 1'b1);
        issue("R8 boot below", 2'd0, 16'hEFFF, 1'b1);
        idle(2);

        // R2 / R6 blank flash opens without ID
        do_reset();
        #2;
        check("R1 after second reset", int'(unlocked), 0);
        @(negedge clk);
        flash_blank = 1'b1;
        issue("R2 command while blank", 2'd2, 16'h9000, 1'b0);
        flash_blank = 1'b0;
        m_unl = 1'b1;
        #2;
        check("R2 unlocked by blank", int'(unlocked), 1);
        idle(3);
        check("R6 unlocked holds", int'(unlocked), 1);
        check("R11 no reject yet", int'(err_sticky), 0);
        @(negedge clk);
        issue("R6 program after blank drops", 2'd1, 16'hE000, 1'b0);
        idle(3);
        check("R10 queue drained", sb.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule